// File: doc/BRIEF.md
# Ethernet MAC Flow-Control Engine

This block handles MAC flow control in both directions. On the transmit side it takes decoded pause events from the MAC receiver, each with a 16-bit quanta value. It loads a receive pause timer and holds off the transmitter while that timer runs. It only asserts or releases the hold between frames.

On the receive side it compares a free-buffer count against a threshold for each receive channel. When any enabled channel runs low, it applies backpressure in one of two ways, depending on the duplex setting. In full duplex it issues outgoing pause requests over a valid/ready stream to the frame builder. In half duplex it asks the PHY side to force collisions on incoming traffic.

The pause request stream follows the usual handshake:
- Once `pause_req_valid` is high, it stays high and `pause_req_quanta` stays unchanged until a cycle in which `pause_req_ready` is also high.
- That cycle is the transfer.
- The sink may hold `pause_req_ready` low for as long as it needs.

The pause events from the receiver are a plain one-cycle strobe and are always accepted.

Top module: `mac_flow_ctrl`

## Requirements
- R1: After reset, both pause timers read 0, and `tx_hold`, `pause_req_valid` and `force_col` are 0.
- R2: A pause event sampled while `cfg_full_duplex` and `cfg_tx_flow_en` are both 1 loads `rx_pause_timer` with its quanta at that edge. `tx_hold` follows one edge later when no frame is in progress.
- R3: A pause event sampled while either `cfg_full_duplex` or `cfg_tx_flow_en` is 0 is ignored: `rx_pause_timer` reads 0 and `tx_hold` stays 0.
- R4: `rx_pause_timer` decreases by one every `QUANTUM_CYC` clock cycles (one quantum of 512 bit times) and stops at 0. `tx_hold` is released one edge after the timer reaches 0.
- R5: A new pause event reloads the timer whatever its current value. A quanta of 0 clears the timer at once, and the hold drops one edge later.
- R6: `tx_hold` changes only on edges where `tx_frame_active` is 0, so a frame in progress is never cut and never released early.
- R7: Channel i triggers when `chan_en[i]` is 1, `cfg_rx_flow_en` is 1 and its free count is less than or equal to its threshold. Each channel's free count and threshold sit at bits [i*16 +: 16] of `free_cnt` and `thresh`. The combined trigger is registered, one edge after the inputs.
- R8: In full duplex, a trigger raises `pause_req_valid` with `pause_req_quanta` equal to `cfg_pause_quanta` two edges after the threshold inputs change. Valid and quanta stay stable until `pause_req_ready`. The accepted quanta loads `tx_pause_timer`, which counts down like the receive timer.
- R9: While the trigger persists, a new request with `cfg_pause_quanta` is raised one edge after `tx_pause_timer` drops to `cfg_pause_quanta/2` (floor).
- R10: When the trigger clears after a nonzero request was sent, exactly one request with quanta 0 is issued, and `tx_pause_timer` then reads 0.
- R11: In half duplex, `force_col` equals the registered trigger ANDed with `rx_carrier`, and no pause request is raised. In full duplex `force_col` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| cfg_tx_flow_en | input | 1 | Act on received pause events |
| cfg_rx_flow_en | input | 1 | Enable receive-side backpressure |
| cfg_pause_quanta | input | 16 | Quanta placed in outgoing pause requests |
| pause_ev | input | 1 | One-cycle strobe: a pause frame was received |
| pause_ev_quanta | input | 16 | Quanta carried by that pause frame |
| tx_frame_active | input | 1 | Transmitter is inside a frame |
| tx_hold | output | 1 | Do not start a new frame |
| chan_en | input | NUM_CH | Per-channel enable for threshold checking |
| free_cnt | input | NUM_CH*16 | Per-channel free-buffer counts |
| thresh | input | NUM_CH*16 | Per-channel thresholds |
| rx_carrier | input | 1 | An incoming frame is on the wire |
| force_col | output | 1 | Force a collision (half duplex) |
| pause_req_valid | output | 1 | Outgoing pause request valid |
| pause_req_ready | input | 1 | Frame builder accepts the request |
| pause_req_quanta | output | 16 | Quanta of the outgoing pause request |
| rx_pause_timer | output | 16 | Current receive pause timer |
| tx_pause_timer | output | 16 | Current transmit pause timer |

## Verification
Each result is due at its own edge:
- A pause event changes `rx_pause_timer` at the edge that samples it, and `tx_hold` one edge later.
- Threshold inputs reach `force_col` after one edge and `pause_req_valid` after two.
- A repeat request appears one edge after the transmit timer reaches half.

The bench drives every input at a falling edge and samples at a later falling edge, counting exactly those edges. For the countdown it computes the expected timer as the quanta minus the number of whole quanta elapsed, and the expected hold from the timer one edge earlier.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
  localparam int QUANTA_W = 16;
  typedef logic [QUANTA_W-1:0] quanta_t;
  typedef enum logic { GEN_IDLE = 1'b0, GEN_PAUSING = 1'b1 } gen_state_e;
endpackage

// File: rtl/fc_quanta_timer.sv
module fc_quanta_timer #(
  parameter int QW          = 16,
  parameter int QUANTUM_CYC = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [QW-1:0] load_val,
  output logic [QW-1:0] count
);
  localparam int PW = $clog2(QUANTUM_CYC + 1);
  localparam logic [PW-1:0] LAST = PW'(QUANTUM_CYC - 1);

  logic [PW-1:0] presc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      presc <= '0;
    end else if (clr) begin
      count <= '0;
      presc <= '0;
    end else if (load) begin
      count <= load_val;
      presc <= '0;
    end else if (count != '0) begin
      if (presc == LAST) begin
        presc <= '0;
        count <= count - 1'b1;
      end else begin
        presc <= presc + 1'b1;
      end
    end
  end

  assert_load_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (count == $past(load_val)));
  assert_never_counts_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (count <= $past(count)));
endmodule

// File: rtl/fc_rx_pause.sv
module fc_rx_pause
  import flowctl_pkg::*;
#(
  parameter int QUANTUM_CYC = 64
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    full_duplex,
  input  logic    tx_flow_en,
  input  logic    pause_ev,
  input  quanta_t pause_ev_quanta,
  input  logic    tx_frame_active,
  output logic    tx_hold,
  output quanta_t timer
);
  logic gate;
  logic hold_q;

  assign gate = full_duplex & tx_flow_en;

  fc_quanta_timer #(.QW(QUANTA_W), .QUANTUM_CYC(QUANTUM_CYC)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (~gate),
    .load     (pause_ev & gate),
    .load_val (pause_ev_quanta),
    .count    (timer)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                hold_q <= 1'b0;
    else if (!tx_frame_active) hold_q <= (timer != '0);
  end

  assign tx_hold = hold_q;

  assert_gate_off_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> (timer == '0));
  assert_hold_frozen_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_frame_active |=> (tx_hold == $past(tx_hold)));
endmodule

// File: rtl/fc_thresh_cmp.sv
module fc_thresh_cmp #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_flow_en,
  input  logic [NUM_CH-1:0]       chan_en,
  input  logic [NUM_CH*CNT_W-1:0] free_cnt,
  input  logic [NUM_CH*CNT_W-1:0] thresh,
  output logic                    trig
);
  logic [NUM_CH-1:0] hit;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign hit[i] = chan_en[i] & (free_cnt[i*CNT_W +: CNT_W] <= thresh[i*CNT_W +: CNT_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trig <= 1'b0;
    else        trig <= rx_flow_en & (|hit);
  end

  assert_disabled_no_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_flow_en |=> !trig);
endmodule

// File: rtl/fc_pause_gen.sv
module fc_pause_gen
  import flowctl_pkg::*;
#(
  parameter int QUANTUM_CYC = 64
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pause_on,
  input  quanta_t cfg_quanta,
  output logic    req_valid,
  input  logic    req_ready,
  output quanta_t req_quanta,
  output quanta_t timer
);
  gen_state_e state;
  logic       fire;
  quanta_t    half;

  assign fire = req_valid & req_ready;
  assign half = cfg_quanta >> 1;

  fc_quanta_timer #(.QW(QUANTA_W), .QUANTUM_CYC(QUANTUM_CYC)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (1'b0),
    .load     (fire),
    .load_val (req_quanta),
    .count    (timer)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= GEN_IDLE;
      req_valid  <= 1'b0;
      req_quanta <= '0;
    end else if (fire) begin
      req_valid <= 1'b0;
      state     <= (req_quanta != '0) ? GEN_PAUSING : GEN_IDLE;
    end else if (!req_valid) begin
      case (state)
        GEN_IDLE: begin
          if (pause_on) begin
            req_valid  <= 1'b1;
            req_quanta <= cfg_quanta;
          end
        end
        GEN_PAUSING: begin
          if (!pause_on) begin
            req_valid  <= 1'b1;
            req_quanta <= '0;
          end else if (timer <= half) begin
            req_valid  <= 1'b1;
            req_quanta <= cfg_quanta;
          end
        end
        default: state <= GEN_IDLE;
      endcase
    end
  end

  assert_req_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_quanta)));
  assert_timer_loads_sent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (timer == $past(req_quanta)));
endmodule

// File: rtl/mac_flow_ctrl.sv
module mac_flow_ctrl
  import flowctl_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int CNT_W       = 16,
  parameter int QUANTUM_CYC = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_full_duplex,
  input  logic                    cfg_tx_flow_en,
  input  logic                    cfg_rx_flow_en,
  input  logic [15:0]             cfg_pause_quanta,
  input  logic                    pause_ev,
  input  logic [15:0]             pause_ev_quanta,
  input  logic                    tx_frame_active,
  output logic                    tx_hold,
  input  logic [NUM_CH-1:0]       chan_en,
  input  logic [NUM_CH*CNT_W-1:0] free_cnt,
  input  logic [NUM_CH*CNT_W-1:0] thresh,
  input  logic                    rx_carrier,
  output logic                    force_col,
  output logic                    pause_req_valid,
  input  logic                    pause_req_ready,
  output logic [15:0]             pause_req_quanta,
  output logic [15:0]             rx_pause_timer,
  output logic [15:0]             tx_pause_timer
);
  logic trig;

  fc_rx_pause #(.QUANTUM_CYC(QUANTUM_CYC)) u_rxp (
    .clk             (clk),
    .rst_n           (rst_n),
    .full_duplex     (cfg_full_duplex),
    .tx_flow_en      (cfg_tx_flow_en),
    .pause_ev        (pause_ev),
    .pause_ev_quanta (pause_ev_quanta),
    .tx_frame_active (tx_frame_active),
    .tx_hold         (tx_hold),
    .timer           (rx_pause_timer)
  );

  fc_thresh_cmp #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_flow_en (cfg_rx_flow_en),
    .chan_en    (chan_en),
    .free_cnt   (free_cnt),
    .thresh     (thresh),
    .trig       (trig)
  );

  fc_pause_gen #(.QUANTUM_CYC(QUANTUM_CYC)) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .pause_on   (trig & cfg_full_duplex),
    .cfg_quanta (cfg_pause_quanta),
    .req_valid  (pause_req_valid),
    .req_ready  (pause_req_ready),
    .req_quanta (pause_req_quanta),
    .timer      (tx_pause_timer)
  );

  assign force_col = trig & ~cfg_full_duplex & rx_carrier;

  assert_col_only_half_R11: assert property (@(posedge clk) disable iff (!rst_n)
    force_col |-> !cfg_full_duplex);
endmodule

// File: tb/sim_mac_flow_ctrl.sv
module sim_mac_flow_ctrl;
  localparam int NCH = 8;
  localparam int CW  = 16;
  localparam int QC  = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic fd, txen, rxen;
  logic [15:0] cfg_q;
  logic ev;
  logic [15:0] ev_q;
  logic frame_act;
  logic hold;
  logic [NCH-1:0] en;
  logic [NCH*CW-1:0] fcnt, thr;
  logic carrier, fcol;
  logic rv, rr;
  logic [15:0] rq, rxt, txt;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mac_flow_ctrl #(.NUM_CH(NCH), .CNT_W(CW), .QUANTUM_CYC(QC)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_full_duplex(fd), .cfg_tx_flow_en(txen), .cfg_rx_flow_en(rxen),
    .cfg_pause_quanta(cfg_q),
    .pause_ev(ev), .pause_ev_quanta(ev_q),
    .tx_frame_active(frame_act), .tx_hold(hold),
    .chan_en(en), .free_cnt(fcnt), .thresh(thr),
    .rx_carrier(carrier), .force_col(fcol),
    .pause_req_valid(rv), .pause_req_ready(rr), .pause_req_quanta(rq),
    .rx_pause_timer(rxt), .tx_pause_timer(txt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic int exp_timer(input int q, input int n);
    int v = q - (n / QC);
    return (v < 0) ? 0 : v;
  endfunction

  task automatic send_ev(input int q);
    ev = 1'b1;
    ev_q = 16'(q);
    step();
    ev = 1'b0;
  endtask

  task automatic set_ch(input int c, input int f, input int t);
    fcnt[c*CW +: CW] = 16'(f);
    thr[c*CW +: CW]  = 16'(t);
  endtask

  task automatic ch_defaults();
    for (int c = 0; c < NCH; c++) set_ch(c, 100, 10);
    en = '1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, run hung");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    int q, n, c, f, t, e, zc, nzc, got;
    seed = $urandom(32'h5eed);
    rst_n = 1'b0; fd = 1'b1; txen = 1'b1; rxen = 1'b1; cfg_q = 16'd20;
    ev = 1'b0; ev_q = '0; frame_act = 1'b0; carrier = 1'b0; rr = 1'b0;
    ch_defaults();
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 rx timer", rxt, 0);
    chk("R1 tx timer", txt, 0);
    chk("R1 hold", hold, 0);
    chk("R1 req valid", rv, 0);
    chk("R1 force_col", fcol, 0);

    // R3 ignored pause events
    fd = 1'b0;
    send_ev(9);
    chk("R3 half duplex timer", rxt, 0);
    step();
    chk("R3 half duplex hold", hold, 0);
    fd = 1'b1; txen = 1'b0;
    send_ev(9);
    chk("R3 tx flow off timer", rxt, 0);
    step();
    chk("R3 tx flow off hold", hold, 0);
    txen = 1'b1;

    // R2 load and hold
    send_ev(10);
    chk("R2 timer loaded", rxt, 10);
    chk("R2 hold not yet", hold, 0);
    step();
    chk("R2 hold set", hold, 1);

    // R4/R5 random quanta with reload
    for (int it = 0; it < 8; it++) begin
      q = int'($urandom % 30) + 1;
      n = int'($urandom % (q * QC + 8)) + 1;
      send_ev(q);
      repeat (n) step();
      chk("R4 countdown", rxt, exp_timer(q, n));
      chk("R4 hold follows", hold, (exp_timer(q, n - 1) != 0) ? 1 : 0);
    end

    // R5 zero quanta releases
    send_ev(20);
    step();
    send_ev(0);
    chk("R5 zero clears timer", rxt, 0);
    chk("R5 hold still one", hold, 1);
    step();
    chk("R5 hold released", hold, 0);

    // R6 frame boundary
    frame_act = 1'b1;
    send_ev(15);
    chk("R6 timer loaded in frame", rxt, 15);
    repeat (3) step();
    chk("R6 no hold mid frame", hold, 0);
    frame_act = 1'b0;
    step();
    chk("R6 hold at boundary", hold, 1);
    frame_act = 1'b1;
    send_ev(0);
    repeat (3) step();
    chk("R6 no release mid frame", hold, 1);
    frame_act = 1'b0;
    step();
    chk("R6 release at boundary", hold, 0);

    // R7 / R11 thresholds in half duplex
    fd = 1'b0; carrier = 1'b1;
    set_ch(3, 11, 10); step();
    chk("R7 above threshold", fcol, 0);
    set_ch(3, 10, 10); step();
    chk("R7 equal threshold", fcol, 1);
    carrier = 1'b0; step();
    chk("R11 no carrier no collision", fcol, 0);
    carrier = 1'b1;
    en[3] = 1'b0; step();
    chk("R7 disabled channel", fcol, 0);
    en[3] = 1'b1; rxen = 1'b0; step();
    chk("R7 rx flow off", fcol, 0);
    rxen = 1'b1; step();
    chk("R11 no request in half duplex", rv, 0);
    for (int it = 0; it < 10; it++) begin
      ch_defaults();
      c = int'($urandom % NCH);
      f = int'($urandom % 24);
      t = int'($urandom % 20);
      e = int'($urandom % 2);
      set_ch(c, f, t);
      en[c] = e[0];
      step();
      chk("R7 random channel", fcol, (e == 1 && f <= t) ? 1 : 0);
    end
    ch_defaults();
    step();
    chk("R11 clear after random", fcol, 0);

    // R8 full duplex request
    fd = 1'b1; rr = 1'b0; cfg_q = 16'd20;
    repeat (4) step();
    set_ch(2, 5, 10);
    step();
    chk("R11 no collision in full duplex", fcol, 0);
    chk("R8 not yet valid", rv, 0);
    step();
    chk("R8 valid", rv, 1);
    chk("R8 quanta", rq, 20);
    repeat (5) step();
    chk("R8 valid held", rv, 1);
    chk("R8 quanta held", rq, 20);
    rr = 1'b1;
    step();
    chk("R8 accepted", rv, 0);
    chk("R8 tx timer loaded", txt, 20);

    // R9 repeat at half
    got = 0;
    for (int k = 0; k < 200; k++) begin
      step();
      if (rv) begin got = 1; break; end
    end
    chk("R9 repeat seen", got, 1);
    chk("R9 tx timer at half", txt, 10);
    chk("R9 repeat quanta", rq, 20);
    step();

    // R10 release
    set_ch(2, 100, 10);
    zc = 0; nzc = 0;
    for (int k = 0; k < 12; k++) begin
      step();
      if (rv && rq == 0) zc++;
      if (rv && rq != 0) nzc++;
    end
    chk("R10 one zero request", zc, 1);
    chk("R10 no further pause", nzc, 0);
    chk("R10 tx timer zero", txt, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule